// File: doc/BRIEF.md
# Watchdog Register Interface with Key-Sequence Write Protection

This block is the register-side front end of a two-stage watchdog. It sits on a simple valid/write/address/data bus and decodes the registers the watchdog core needs. These are two preload values, one for each countdown stage, a reload register, a status slot, a configuration register and a lock register. It passes their contents to the core as plain level outputs. The core does the counting and is not part of this block.

Writes to the preload registers and reload actions are protected. They are accepted only right after a two-word key has been written to the reload offset. The first key word is `0x80` and the second is `0x86`. Any other write closes the protection again, so every protected access needs a fresh key.

An accepted reload write can do two things. It can pulse a ping that restarts the core, and it can pulse a clear for the core's previous-reboot flag. The clear is requested through either of two bits, one of which is a compatibility alias. Reading the reload offset reports that flag in a fixed, driver-compatible encoding.

Top module: `wdt_regif`

## Requirements
- R1: After reset both preload values read `0xFFFFF`, the configuration and lock registers read 0, reboot is enabled, and the ping and flag-clear outputs are low.
- R2: A write of exactly `0x80` to offset `0x0C` always puts the key sequencer into its half-open state. A write of exactly `0x86` to offset `0x0C` opens it only from the half-open state. The key therefore works only as `0x80` followed immediately by `0x86`.
- R3: While the key is open, a write to offset `0x00` (stage 1) or `0x04` (stage 2) stores the low 20 bits of the data. That value appears on the matching preload output and reads back zero-extended. While the key is closed, the write has no effect.
- R4: Any write that is not a key word closes the key, whatever its offset. This includes a protected write that was accepted, so a second protected write without a new key is ignored.
- R5: An accepted reload write with bit 8 set drives `ping_o` high for exactly one cycle, in the cycle after the write. A reload write with the key closed produces no ping.
- R6: An accepted reload write with bit 9 or bit 12 set drives `flag_clr_o` high for exactly one cycle, in the cycle after the write. A reload write with the key closed produces no clear.
- R7: A read of offset `0x0C` returns `0x1200` while `prev_reboot_i` is high and 0 otherwise.
- R8: The lock register at offset `0x14` has lock in bit 0, enable in bit 1 and free-run in bit 2. Lock and free-run always take the written value. Enable takes the written value only if lock was clear before the write; otherwise enable keeps its value.
- R9: The configuration register at offset `0x10` has reboot-disable in bit 5, the fast clock select in bit 2 and the interrupt kind in bits 1:0. It reads back with the same encoding and other bits zero, and `reboot_en_o` is the inverse of bit 5.
- R10: The status offset `0x08` and every undecoded offset read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| prev_reboot_i | input | 1 | Previous-reboot flag held by the core |
| stage1_preload_o | output | PRELOAD_W | Stage 1 countdown preload |
| stage2_preload_o | output | PRELOAD_W | Stage 2 countdown preload |
| ping_o | output | 1 | One-cycle restart request |
| flag_clr_o | output | 1 | One-cycle request to clear the previous-reboot flag |
| wdt_enable_o | output | 1 | Watchdog enable |
| wdt_lock_o | output | 1 | Lock that freezes the enable |
| free_run_o | output | 1 | Restart stage 1 after the final expiry |
| reboot_en_o | output | 1 | Reboot on final expiry enabled |
| fast_clk_o | output | 1 | Fast count clock selected |
| irq_kind_o | output | 2 | Stage 1 interrupt kind |

## Verification
The key sequencer state is not visible at any port. Its state is inferred from whether the following preload write lands. The bench walks every ordered pair from a small set of key and non-key words, writes a preload after each pair, and expects the write to be accepted only after the `0x80`, `0x86` pair. Enable freezing is reached by first driving the lock register to every one of its eight states and then writing each of the eight values on top of it.

// File: rtl/wdt_regif_pkg.sv
package wdt_regif_pkg;

    localparam logic [15:0] OFS_PRE1   = 16'h0000;
    localparam logic [15:0] OFS_PRE2   = 16'h0004;
    localparam logic [15:0] OFS_STAT   = 16'h0008;
    localparam logic [15:0] OFS_RELOAD = 16'h000C;
    localparam logic [15:0] OFS_CFG    = 16'h0010;
    localparam logic [15:0] OFS_LOCK   = 16'h0014;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    localparam int RL_PING      = 8;
    localparam int RL_CLR       = 9;
    localparam int RL_CLR_ALIAS = 12;
    localparam logic [31:0] RL_FLAG_WORD = 32'h0000_1200;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_HALF = 2'd1,
        KEY_OPEN = 2'd2
    } key_state_e;

    // Stage preload selects occupy the first codes so stage i maps to code i.
    typedef enum logic [2:0] {
        SEL_PRE1   = 3'd0,
        SEL_PRE2   = 3'd1,
        SEL_STAT   = 3'd2,
        SEL_RELOAD = 3'd3,
        SEL_CFG    = 3'd4,
        SEL_LOCK   = 3'd5,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic       no_reboot;
        logic       fast_clk;
        logic [1:0] irq_kind;
    } cfg_t;

    typedef struct packed {
        logic free_run;
        logic enable;
        logic lock;
    } lock_t;

    function automatic reg_sel_e decode_ofs(input logic [15:0] ofs);
        case (ofs)
            OFS_PRE1:   return SEL_PRE1;
            OFS_PRE2:   return SEL_PRE2;
            OFS_STAT:   return SEL_STAT;
            OFS_RELOAD: return SEL_RELOAD;
            OFS_CFG:    return SEL_CFG;
            OFS_LOCK:   return SEL_LOCK;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic cfg_t cfg_from_word(input logic [31:0] w);
        cfg_t c;
        c.no_reboot = w[5];
        c.fast_clk  = w[2];
        c.irq_kind  = w[1:0];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input cfg_t c);
        logic [31:0] w;
        w      = '0;
        w[5]   = c.no_reboot;
        w[2]   = c.fast_clk;
        w[1:0] = c.irq_kind;
        return w;
    endfunction

    function automatic lock_t lock_from_word(input logic [31:0] w);
        lock_t l;
        l.lock     = w[0];
        l.enable   = w[1];
        l.free_run = w[2];
        return l;
    endfunction

    function automatic logic [31:0] lock_to_word(input lock_t l);
        return {29'd0, l.free_run, l.enable, l.lock};
    endfunction

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_regif_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       hit_first,
    input  logic       hit_second,
    output key_state_e state
);

    key_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KEY_IDLE;
        end else if (wr_en) begin
            if (hit_first)
                state_q <= KEY_HALF;
            else if (hit_second && state_q == KEY_HALF)
                state_q <= KEY_OPEN;
            else
                state_q <= KEY_IDLE;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/wdt_preload_bank.sv
module wdt_preload_bank #(
    parameter int NUM_STAGES = 2,
    parameter int PRELOAD_W  = 20
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_STAGES-1:0]                 stage_wr,
    input  logic [PRELOAD_W-1:0]                  wdata,
    output logic [NUM_STAGES-1:0][PRELOAD_W-1:0]  preload
);

    localparam logic [PRELOAD_W-1:0] PRELOAD_RST = '1;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        logic [PRELOAD_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst)
                val_q <= PRELOAD_RST;
            else if (stage_wr[i])
                val_q <= wdata;
        end
        assign preload[i] = val_q;
    end

endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import wdt_regif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_wr,
    input  cfg_t  cfg_new,
    input  logic  lock_wr,
    input  lock_t lock_new,
    output cfg_t  cfg,
    output lock_t lock_reg
);

    cfg_t  cfg_q;
    lock_t lock_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_wr)
            cfg_q <= cfg_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '0;
        end else if (lock_wr) begin
            lock_q.lock     <= lock_new.lock;
            lock_q.free_run <= lock_new.free_run;
            if (!lock_q.lock)
                lock_q.enable <= lock_new.enable;
        end
    end

    assign cfg      = cfg_q;
    assign lock_reg = lock_q;

endmodule

// File: rtl/wdt_regif.sv
module wdt_regif
    import wdt_regif_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int PRELOAD_W  = 20,
    parameter int NUM_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 prev_reboot_i,
    output logic [PRELOAD_W-1:0] stage1_preload_o,
    output logic [PRELOAD_W-1:0] stage2_preload_o,
    output logic                 ping_o,
    output logic                 flag_clr_o,
    output logic                 wdt_enable_o,
    output logic                 wdt_lock_o,
    output logic                 free_run_o,
    output logic                 reboot_en_o,
    output logic                 fast_clk_o,
    output logic [1:0]           irq_kind_o
);

    localparam logic [DATA_W-1:0] KEY1_WORD = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] KEY2_WORD = DATA_W'(KEY_SECOND);

    logic       wr_en;
    logic       rd_en;
    reg_sel_e   sel;
    logic       hit_first;
    logic       hit_second;
    key_state_e key_state;
    logic       prot_wr;
    logic [31:0] wword;

    assign wr_en      = bus_valid & bus_write;
    assign rd_en      = bus_valid & ~bus_write;
    assign sel        = decode_ofs(16'(bus_addr));
    assign hit_first  = (sel == SEL_RELOAD) && (bus_wdata == KEY1_WORD);
    assign hit_second = (sel == SEL_RELOAD) && (bus_wdata == KEY2_WORD);
    assign wword      = 32'(bus_wdata);

    wdt_key_seq u_key (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .hit_first  (hit_first),
        .hit_second (hit_second),
        .state      (key_state)
    );

    assign prot_wr = wr_en && (key_state == KEY_OPEN);

    // Preload bank: stage i is written through select code i.
    logic [NUM_STAGES-1:0]                stage_wr;
    logic [NUM_STAGES-1:0][PRELOAD_W-1:0] preload;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_wsel
        assign stage_wr[i] = prot_wr && (sel == reg_sel_e'(i));
    end

    wdt_preload_bank #(
        .NUM_STAGES (NUM_STAGES),
        .PRELOAD_W  (PRELOAD_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .stage_wr (stage_wr),
        .wdata    (bus_wdata[PRELOAD_W-1:0]),
        .preload  (preload)
    );

    assign stage1_preload_o = preload[0];
    assign stage2_preload_o = preload[1];

    // Reload strobes
    logic reload_ok;
    logic ping_q;
    logic clr_q;

    assign reload_ok = prot_wr && (sel == SEL_RELOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ping_q <= 1'b0;
            clr_q  <= 1'b0;
        end else begin
            ping_q <= reload_ok && wword[RL_PING];
            clr_q  <= reload_ok && (wword[RL_CLR] || wword[RL_CLR_ALIAS]);
        end
    end

    assign ping_o     = ping_q;
    assign flag_clr_o = clr_q;

    // Configuration and lock
    cfg_t  cfg;
    lock_t lock_reg;

    wdt_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (wr_en && (sel == SEL_CFG)),
        .cfg_new  (cfg_from_word(wword)),
        .lock_wr  (wr_en && (sel == SEL_LOCK)),
        .lock_new (lock_from_word(wword)),
        .cfg      (cfg),
        .lock_reg (lock_reg)
    );

    assign wdt_enable_o = lock_reg.enable;
    assign wdt_lock_o   = lock_reg.lock;
    assign free_run_o   = lock_reg.free_run;
    assign reboot_en_o  = ~cfg.no_reboot;
    assign fast_clk_o   = cfg.fast_clk;
    assign irq_kind_o   = cfg.irq_kind;

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_PRE1:   bus_rdata = DATA_W'(preload[0]);
                SEL_PRE2:   bus_rdata = DATA_W'(preload[1]);
                SEL_RELOAD: bus_rdata = prev_reboot_i ? DATA_W'(RL_FLAG_WORD) : '0;
                SEL_CFG:    bus_rdata = DATA_W'(cfg_to_word(cfg));
                SEL_LOCK:   bus_rdata = DATA_W'(lock_to_word(lock_reg));
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_regif_chk.sv
module wdt_regif_chk
    import wdt_regif_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int PRELOAD_W = 20
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 ping_o,
    input logic                 flag_clr_o,
    input logic                 wdt_enable_o,
    input logic                 wdt_lock_o,
    input logic [PRELOAD_W-1:0] stage1_preload_o,
    input key_state_e           key_state
);

    logic wr, at_reload, at_pre1, is_k1, is_k2, key_word;

    assign wr        = bus_valid && bus_write;
    assign at_reload = bus_addr == ADDR_W'(OFS_RELOAD);
    assign at_pre1   = bus_addr == ADDR_W'(OFS_PRE1);
    assign is_k1     = bus_wdata == DATA_W'(KEY_FIRST);
    assign is_k2     = bus_wdata == DATA_W'(KEY_SECOND);
    assign key_word  = at_reload && (is_k1 || (is_k2 && key_state == KEY_HALF));

    // R2: second key word outside the half-open state does not open
    p_second_needs_half_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && at_reload && is_k2 && key_state != KEY_HALF) |=> key_state == KEY_IDLE);

    // R4: non-key writes close the key
    p_relock_on_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && !key_word) |=> key_state == KEY_IDLE);

    // R3: stage 1 preload moves only on an open-key write to its offset
    p_preload_guard_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr && at_pre1 && key_state == KEY_OPEN) |=> $stable(stage1_preload_o));

    // R5: ping only after an accepted reload write with the ping bit
    p_ping_gated_r5: assert property (@(posedge clk) disable iff (rst)
        ping_o |-> $past(wr && at_reload && key_state == KEY_OPEN && bus_wdata[RL_PING]));

    // R6: flag clear only after an accepted reload write with a clear bit
    p_clr_gated_r6: assert property (@(posedge clk) disable iff (rst)
        flag_clr_o |-> $past(wr && at_reload && key_state == KEY_OPEN
                             && (bus_wdata[RL_CLR] || bus_wdata[RL_CLR_ALIAS])));

    // R8: enable is frozen while lock is set
    p_enable_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_lock_o |=> $stable(wdt_enable_o));

endmodule

bind wdt_regif wdt_regif_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PRELOAD_W (PRELOAD_W)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_valid        (bus_valid),
    .bus_write        (bus_write),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .ping_o           (ping_o),
    .flag_clr_o       (flag_clr_o),
    .wdt_enable_o     (wdt_enable_o),
    .wdt_lock_o       (wdt_lock_o),
    .stage1_preload_o (stage1_preload_o),
    .key_state        (key_state)
);

// File: tb/sim_wdt_regif.sv
module sim_wdt_regif;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        prev_reboot_i = 1'b0;
    logic [19:0] stage1_preload_o, stage2_preload_o;
    logic        ping_o, flag_clr_o, wdt_enable_o, wdt_lock_o, free_run_o;
    logic        reboot_en_o, fast_clk_o;
    logic [1:0]  irq_kind_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_regif u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prev_reboot_i(prev_reboot_i), .stage1_preload_o(stage1_preload_o),
        .stage2_preload_o(stage2_preload_o), .ping_o(ping_o), .flag_clr_o(flag_clr_o),
        .wdt_enable_o(wdt_enable_o), .wdt_lock_o(wdt_lock_o), .free_run_o(free_run_o),
        .reboot_en_o(reboot_en_o), .fast_clk_o(fast_clk_o), .irq_kind_o(irq_kind_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic unlock();
        wr(8'h0C, 32'h80);
        wr(8'h0C, 32'h86);
    endtask

    logic [31:0] keyw [4] = '{32'h80, 32'h86, 32'h00, 32'h100};

    initial begin
        logic [31:0] d;
        logic [19:0] exp1, exp2;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(8'h00, d); chk("R1 pre1", d, 32'hFFFFF);
        rd(8'h04, d); chk("R1 pre2", d, 32'hFFFFF);
        rd(8'h10, d); chk("R1 cfg", d, 0);
        rd(8'h14, d); chk("R1 lock", d, 0);
        chk("R1 reboot_en", reboot_en_o, 1);
        chk("R1 strobes", {ping_o, flag_clr_o}, 0);

        // R10 undecoded and status offsets read zero, writes ignored
        for (int a = 8; a < 256; a += 4) begin
            if (a == 8'h0C || a == 8'h10 || a == 8'h14) continue;
            rd(8'(a), d); chk("R10 read", d, 0);
        end
        rd(8'h01, d); chk("R10 odd offset", d, 0);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R10 cfg untouched", d, 0);
        rd(8'h14, d); chk("R10 lock untouched", d, 0);
        rd(8'h00, d); chk("R10 pre1 untouched", d, 32'hFFFFF);

        // R2 key pairs: only 0x80 then 0x86 opens
        exp1 = 20'hFFFFF;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                logic [19:0] v;
                v = 20'(32'h5A000 + a * 16 + b);
                wr(8'h10, 0);
                wr(8'h0C, keyw[a]);
                wr(8'h0C, keyw[b]);
                wr(8'h00, {12'hABC, v});
                if (a == 0 && b == 1) exp1 = v;
                chk("R2 key pair", stage1_preload_o, exp1);
            end
        end

        // R3 masking and readback on both stages
        exp2 = 20'hFFFFF;
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v;
            v = 32'hF0F0_0000 ^ (32'h1_1111 * k);
            unlock(); wr(8'h00, v); exp1 = v[19:0];
            unlock(); wr(8'h04, ~v); exp2 = ~v[19:0];
            rd(8'h00, d); chk("R3 pre1 mask", d, {12'd0, exp1});
            rd(8'h04, d); chk("R3 pre2 mask", d, {12'd0, exp2});
            chk("R3 pre2 port", stage2_preload_o, exp2);
        end
        wr(8'h04, 32'h12345);
        chk("R3 locked write", stage2_preload_o, exp2);

        // R4 relock after accepted write and after unrelated write
        unlock(); wr(8'h00, 32'h11111); wr(8'h00, 32'h22222);
        chk("R4 second write", stage1_preload_o, 20'h11111);
        unlock(); wr(8'h10, 0); wr(8'h04, 32'h33333);
        chk("R4 cfg write relocks", stage2_preload_o, exp2);
        unlock(); wr(8'h20, 0); wr(8'h04, 32'h44444);
        chk("R4 undecoded write relocks", stage2_preload_o, exp2);

        // R5 / R6 reload bit combinations
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v;
            v = (32'(k & 1) << 8) | (32'((k >> 1) & 1) << 9) | (32'((k >> 2) & 1) << 12);
            unlock(); wr(8'h0C, v);
            chk("R5 ping", ping_o, 32'(k & 1));
            chk("R6 clr", flag_clr_o, 32'((k >> 1) != 0));
            @(posedge clk); #1;
            chk("R5 R6 one cycle", {ping_o, flag_clr_o}, 0);
            wr(8'h0C, v);
            chk("R5 R6 closed key", {ping_o, flag_clr_o}, 0);
        end

        // R7 reload readback
        prev_reboot_i = 1'b1; rd(8'h0C, d); chk("R7 flag set", d, 32'h1200);
        prev_reboot_i = 1'b0; rd(8'h0C, d); chk("R7 flag clear", d, 0);

        // R8 lock register: every prior state against every write
        for (int p = 0; p < 8; p++) begin
            for (int v = 0; v < 8; v++) begin
                logic [2:0] e;
                wr(8'h14, 0); wr(8'h14, 0);
                wr(8'h14, 32'(p));
                wr(8'h14, 32'(v));
                e = 3'(v);
                if (p & 1) e[1] = 1'((p >> 1) & 1);
                rd(8'h14, d); chk("R8 lock readback", d, {29'd0, e});
                chk("R8 ports", {free_run_o, wdt_enable_o, wdt_lock_o}, {29'd0, e});
            end
        end

        // R9 config encoding
        for (int v = 0; v < 64; v++) begin
            logic [31:0] w;
            w = 32'(v) | 32'hFF00_0000;
            wr(8'h10, w);
            rd(8'h10, d); chk("R9 cfg readback", d, w & 32'h27);
            chk("R9 ports", {reboot_en_o, fast_clk_o, irq_kind_o},
                {28'd0, ~w[5], w[2], w[1:0]});
        end

        done = 1;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule